// File: doc/BRIEF.md
# Call/Return Address Stack with Fault Reset Request

This block keeps the return addresses of a small processor core in dedicated hardware. A call event strobes `push_i` with the 21-bit return address on `push_addr_i`, and a return event strobes `pop_i`. The address at the top of the stack is always visible on `tos_o`, so the core can branch back without waiting. The stack has 31 usable slots. The stack level is a 5-bit pointer, and software can read it and overwrite it through an 8-bit register view, `ptr_o` and `ptr_wr_i`/`ptr_wdata_i`.

Two faults are detected. The first is a call when all slots are occupied (overflow). The second is a return when the stack is empty (underflow). Each fault sets its own sticky flag, and that flag stays up until software clears it or power-on reset occurs. The configuration input `fault_rst_en_i` sets whether a fault also sends a one-cycle request to the chip's reset controller. The reset controller is outside this block.

Top module: `call_return_stack`

## Requirements
- R1: While `rst_n` is low and after its release, the pointer reads 0, `tos_o` reads 0, and both flags and `rst_req_o` are 0. Bits 7:5 of `ptr_o` always read 0.
- R2: A push while the pointer is below 31 increments the pointer and stores the address in the slot at the new pointer value. From the next cycle, `tos_o` shows that address.
- R3: A push while the pointer is 31 is an overflow. Nothing is stored, the pointer and `tos_o` stay unchanged, and `ovf_flag_o` is 1 from the next cycle.
- R4: A pop while the pointer is above 0 decrements the pointer, and `tos_o` then shows the slot below the one removed.
- R5: A pop while the pointer is 0 is an underflow. The pointer stays at 0, `tos_o` reads 0, and `unf_flag_o` is 1 from the next cycle.
- R6: Each flag stays at 1 until its clear input (`ovf_clr_i` or `unf_clr_i`) is high at a clock edge. If a fault and the matching clear occur in the same cycle, the flag is set.
- R7: When `fault_rst_en_i` is 1 in the cycle of a fault, `rst_req_o` is high for exactly the next cycle.
- R8: When `fault_rst_en_i` is 0 in the cycle of a fault, the flag is still set but `rst_req_o` stays 0.
- R9: If push and pop are both high in one cycle, only the push takes effect, including the overflow case.
- R10: A pointer write loads `ptr_wdata_i[4:0]` into the pointer and ignores bits 7:5. In that cycle, push and pop have no effect.
- R11: Moving the pointer does not change slot contents. After a pointer write, `tos_o` shows whatever that slot last held, or 0 if it was never written since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| push_i | input | 1 | Call event: push `push_addr_i` |
| pop_i | input | 1 | Return event: discard the top slot |
| push_addr_i | input | 21 | Return address to store |
| ptr_wr_i | input | 1 | Software write strobe for the pointer register |
| ptr_wdata_i | input | 8 | Pointer register write data; bits 4:0 used |
| ovf_clr_i | input | 1 | Software clear of the overflow flag |
| unf_clr_i | input | 1 | Software clear of the underflow flag |
| fault_rst_en_i | input | 1 | Configuration: faults also request a device reset |
| tos_o | output | 21 | Address in the top slot (0 when empty) |
| ptr_o | output | 8 | Pointer register view, bits 7:5 zero |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| unf_flag_o | output | 1 | Sticky underflow flag |
| rst_req_o | output | 1 | One-cycle device reset request |

## Verification
The pointer, the flags and the reset request are all registered, so each one responds at the first rising edge after the cycle that holds the stimulus. `tos_o` is a combinational read of the registered pointer and slots, so it settles in that same cycle. The bench changes inputs on the falling edge and samples every output 1 ns after the following rising edge, which is the first point where the result is due. For the reset request it also samples one cycle later, to confirm that the pulse has already dropped.

// File: rtl/crs_pkg.sv
package crs_pkg;

  // Operation chosen for one cycle; software load outranks push, push outranks pop.
  typedef enum logic [1:0] {
    CRS_IDLE = 2'd0,
    CRS_PUSH = 2'd1,
    CRS_POP  = 2'd2,
    CRS_LOAD = 2'd3
  } crs_op_e;

  function automatic crs_op_e crs_pick_op(input logic push, input logic pop, input logic load);
    if (load) return CRS_LOAD;
    if (push) return CRS_PUSH;
    if (pop)  return CRS_POP;
    return CRS_IDLE;
  endfunction

  // Sticky bit: a new set event wins over a clear in the same cycle.
  function automatic logic crs_sticky(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/crs_ptr_ctrl.sv
module crs_ptr_ctrl
  import crs_pkg::*;
#(
  parameter int unsigned PTR_W = 5,
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             load_i,
  input  logic [REG_W-1:0] load_val_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_idx_o,
  output logic             push_ok_o,
  output logic             pop_ok_o,
  output logic             full_evt_o,
  output logic             empty_evt_o
);

  localparam logic [PTR_W-1:0] PTR_TOP  = {PTR_W{1'b1}};
  localparam logic [PTR_W-1:0] PTR_ZERO = '0;

  function automatic logic [PTR_W-1:0] ptr_up(input logic [PTR_W-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_down(input logic [PTR_W-1:0] p);
    return p - 1'b1;
  endfunction

  function automatic logic at_full(input logic [PTR_W-1:0] p);
    return p == PTR_TOP;
  endfunction

  function automatic logic at_empty(input logic [PTR_W-1:0] p);
    return p == PTR_ZERO;
  endfunction

  crs_op_e          op;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;

  always_comb begin
    op          = crs_pick_op(push_i, pop_i, load_i);
    push_ok_o   = (op == CRS_PUSH) && !at_full(ptr_q);
    full_evt_o  = (op == CRS_PUSH) &&  at_full(ptr_q);
    pop_ok_o    = (op == CRS_POP)  && !at_empty(ptr_q);
    empty_evt_o = (op == CRS_POP)  &&  at_empty(ptr_q);
  end

  always_comb begin
    ptr_d = ptr_q;
    unique case (op)
      CRS_LOAD: ptr_d = load_val_i[PTR_W-1:0];
      CRS_PUSH: if (push_ok_o) ptr_d = ptr_up(ptr_q);
      CRS_POP:  if (pop_ok_o)  ptr_d = ptr_down(ptr_q);
      default:  ptr_d = ptr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign wr_en_o  = push_ok_o;
  assign wr_idx_o = ptr_up(ptr_q);
  assign ptr_o    = ptr_q;

endmodule

// File: rtl/crs_storage.sv
module crs_storage #(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned PTR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_data_o
);

  localparam int unsigned SLOTS = 2 ** PTR_W;
  localparam int unsigned DEPTH = SLOTS - 1;

  // Index 0 is the empty level and always reads zero.
  logic [ADDR_W-1:0] slot [SLOTS];

  assign slot[0] = '0;

  for (genvar g = 1; g <= DEPTH; g++) begin : g_slot
    logic [ADDR_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  q <= '0;
      else if (wr_en_i && wr_idx_i == PTR_W'(g))   q <= wr_data_i;
    end
    assign slot[g] = q;
  end

  assign rd_data_o = slot[rd_idx_i];

endmodule

// File: rtl/crs_fault_flags.sv
module crs_fault_flags
  import crs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic full_evt_i,
  input  logic empty_evt_i,
  input  logic ovf_clr_i,
  input  logic unf_clr_i,
  input  logic rst_en_i,
  output logic ovf_flag_o,
  output logic unf_flag_o,
  output logic rst_req_o
);

  logic ovf_q, unf_q, req_q;
  logic any_fault;

  assign any_fault = full_evt_i | empty_evt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      ovf_q <= crs_sticky(ovf_q, full_evt_i, ovf_clr_i);
      unf_q <= crs_sticky(unf_q, empty_evt_i, unf_clr_i);
      req_q <= any_fault & rst_en_i;
    end
  end

  assign ovf_flag_o = ovf_q;
  assign unf_flag_o = unf_q;
  assign rst_req_o  = req_q;

endmodule

// File: rtl/call_return_stack.sv
module call_return_stack #(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned PTR_W  = 5,
  parameter int unsigned REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              ptr_wr_i,
  input  logic [REG_W-1:0]  ptr_wdata_i,
  input  logic              ovf_clr_i,
  input  logic              unf_clr_i,
  input  logic              fault_rst_en_i,
  output logic [ADDR_W-1:0] tos_o,
  output logic [REG_W-1:0]  ptr_o,
  output logic              ovf_flag_o,
  output logic              unf_flag_o,
  output logic              rst_req_o
);

  localparam int unsigned PAD_W = REG_W - PTR_W;

  // Internal events, named for the bound checker.
  logic [PTR_W-1:0] ptr_q;
  logic             wr_en;
  logic [PTR_W-1:0] wr_idx;
  logic             push_ok;
  logic             pop_ok;
  logic             full_evt;
  logic             empty_evt;

  crs_ptr_ctrl #(
    .PTR_W (PTR_W),
    .REG_W (REG_W)
  ) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .load_i      (ptr_wr_i),
    .load_val_i  (ptr_wdata_i),
    .ptr_o       (ptr_q),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx),
    .push_ok_o   (push_ok),
    .pop_ok_o    (pop_ok),
    .full_evt_o  (full_evt),
    .empty_evt_o (empty_evt)
  );

  crs_storage #(
    .ADDR_W (ADDR_W),
    .PTR_W  (PTR_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (push_addr_i),
    .rd_idx_i  (ptr_q),
    .rd_data_o (tos_o)
  );

  crs_fault_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .full_evt_i  (full_evt),
    .empty_evt_i (empty_evt),
    .ovf_clr_i   (ovf_clr_i),
    .unf_clr_i   (unf_clr_i),
    .rst_en_i    (fault_rst_en_i),
    .ovf_flag_o  (ovf_flag_o),
    .unf_flag_o  (unf_flag_o),
    .rst_req_o   (rst_req_o)
  );

  assign ptr_o = {{PAD_W{1'b0}}, ptr_q};

endmodule

// File: rtl/call_return_stack_chk.sv
module call_return_stack_chk #(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned PTR_W  = 5,
  parameter int unsigned REG_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_i,
  input logic              pop_i,
  input logic [ADDR_W-1:0] push_addr_i,
  input logic              ptr_wr_i,
  input logic [REG_W-1:0]  ptr_wdata_i,
  input logic              ovf_clr_i,
  input logic              unf_clr_i,
  input logic              fault_rst_en_i,
  input logic [ADDR_W-1:0] tos_o,
  input logic [REG_W-1:0]  ptr_o,
  input logic              ovf_flag_o,
  input logic              unf_flag_o,
  input logic              rst_req_o,
  input logic              push_ok,
  input logic              pop_ok,
  input logic              full_evt,
  input logic              empty_evt
);

  // R1: one edge after reset is seen low, everything reads its cleared value
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (ptr_o == '0 && tos_o == '0 && !ovf_flag_o && !unf_flag_o && !rst_req_o));

  assert_push_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> ptr_o[PTR_W-1:0] == $past(ptr_o[PTR_W-1:0]) + 1'b1);

  assert_push_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> tos_o == $past(push_addr_i));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full_evt |=> ($stable(ptr_o) && $stable(tos_o) && ovf_flag_o));

  assert_pop_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> ptr_o[PTR_W-1:0] == $past(ptr_o[PTR_W-1:0]) - 1'b1);

  assert_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    empty_evt |=> (ptr_o == '0 && tos_o == '0 && unf_flag_o));

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag_o && !ovf_clr_i) |=> ovf_flag_o);

  assert_unf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_flag_o && !unf_clr_i) |=> unf_flag_o);

  assert_unf_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_clr_i && !empty_evt) |=> !unf_flag_o);

  assert_req_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((full_evt || empty_evt) && fault_rst_en_i) |=> rst_req_o);

  assert_req_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> $past((full_evt || empty_evt) && fault_rst_en_i));

  assert_req_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((full_evt || empty_evt) && !fault_rst_en_i) |=> !rst_req_o);

  assert_push_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !ptr_wr_i) |-> (!pop_ok && !empty_evt));

  assert_load_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_i |=> ptr_o == REG_W'($past(ptr_wdata_i[PTR_W-1:0])));

  assert_load_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_i |-> !(push_ok || pop_ok || full_evt || empty_evt));

endmodule

bind call_return_stack call_return_stack_chk #(
  .ADDR_W (ADDR_W),
  .PTR_W  (PTR_W),
  .REG_W  (REG_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .push_i         (push_i),
  .pop_i          (pop_i),
  .push_addr_i    (push_addr_i),
  .ptr_wr_i       (ptr_wr_i),
  .ptr_wdata_i    (ptr_wdata_i),
  .ovf_clr_i      (ovf_clr_i),
  .unf_clr_i      (unf_clr_i),
  .fault_rst_en_i (fault_rst_en_i),
  .tos_o          (tos_o),
  .ptr_o          (ptr_o),
  .ovf_flag_o     (ovf_flag_o),
  .unf_flag_o     (unf_flag_o),
  .rst_req_o      (rst_req_o),
  .push_ok        (push_ok),
  .pop_ok         (pop_ok),
  .full_evt       (full_evt),
  .empty_evt      (empty_evt)
);

// File: tb/call_return_stack_tb.sv
`timescale 1ns/1ps
module call_return_stack_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 1'b0, pop_i = 1'b0, ptr_wr_i = 1'b0;
  logic [20:0] push_addr_i = '0;
  logic [7:0]  ptr_wdata_i = '0;
  logic        ovf_clr_i = 1'b0, unf_clr_i = 1'b0, fault_rst_en_i = 1'b0;
  logic [20:0] tos_o;
  logic [7:0]  ptr_o;
  logic        ovf_flag_o, unf_flag_o, rst_req_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  call_return_stack u_dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .push_addr_i(push_addr_i),
    .ptr_wr_i(ptr_wr_i), .ptr_wdata_i(ptr_wdata_i), .ovf_clr_i(ovf_clr_i), .unf_clr_i(unf_clr_i),
    .fault_rst_en_i(fault_rst_en_i), .tos_o(tos_o), .ptr_o(ptr_o), .ovf_flag_o(ovf_flag_o),
    .unf_flag_o(unf_flag_o), .rst_req_o(rst_req_o)
  );

  typedef struct packed {
    logic        push, pop, wr;
    logic [7:0]  wdata;
    logic [20:0] addr;
    logic        clr_o, clr_u, en;
    logic [7:0]  e_ptr;
    logic [20:0] e_tos;
    logic        e_ovf, e_unf, e_req;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    // push pop  wr    wdata  addr          clro  clru  en    ptr    tos           ovf   unf   req   req-id
    '{1'b1,1'b0,1'b0,8'h00,21'h10001,1'b0,1'b0,1'b1,8'd1,21'h10001,1'b0,1'b0,1'b0,4'd2},  // R2
    '{1'b1,1'b0,1'b0,8'h00,21'h00A0B,1'b0,1'b0,1'b1,8'd2,21'h00A0B,1'b0,1'b0,1'b0,4'd2},  // R2
    '{1'b1,1'b1,1'b0,8'h00,21'h1FFFF,1'b0,1'b0,1'b1,8'd3,21'h1FFFF,1'b0,1'b0,1'b0,4'd9},  // R9
    '{1'b0,1'b1,1'b0,8'h00,21'h00000,1'b0,1'b0,1'b1,8'd2,21'h00A0B,1'b0,1'b0,1'b0,4'd4},  // R4
    '{1'b0,1'b1,1'b0,8'h00,21'h00000,1'b0,1'b0,1'b1,8'd1,21'h10001,1'b0,1'b0,1'b0,4'd4},  // R4
    '{1'b0,1'b1,1'b0,8'h00,21'h00000,1'b0,1'b0,1'b1,8'd0,21'h00000,1'b0,1'b0,1'b0,4'd4},  // R4
    '{1'b0,1'b1,1'b0,8'h00,21'h00000,1'b0,1'b0,1'b0,8'd0,21'h00000,1'b0,1'b1,1'b0,4'd8},  // R5 R8
    '{1'b0,1'b0,1'b0,8'h00,21'h00000,1'b0,1'b0,1'b1,8'd0,21'h00000,1'b0,1'b1,1'b0,4'd6},  // R6
    '{1'b0,1'b1,1'b0,8'h00,21'h00000,1'b0,1'b0,1'b1,8'd0,21'h00000,1'b0,1'b1,1'b1,4'd7},  // R7
    '{1'b0,1'b0,1'b0,8'h00,21'h00000,1'b0,1'b0,1'b1,8'd0,21'h00000,1'b0,1'b1,1'b0,4'd7},  // R7 pulse ends
    '{1'b0,1'b0,1'b0,8'h00,21'h00000,1'b0,1'b1,1'b1,8'd0,21'h00000,1'b0,1'b0,1'b0,4'd6},  // R6 clear
    '{1'b0,1'b1,1'b0,8'h00,21'h00000,1'b0,1'b1,1'b0,8'd0,21'h00000,1'b0,1'b1,1'b0,4'd6},  // R6 set wins
    '{1'b0,1'b0,1'b0,8'h00,21'h00000,1'b0,1'b1,1'b0,8'd0,21'h00000,1'b0,1'b0,1'b0,4'd6},  // R6
    '{1'b1,1'b0,1'b1,8'hE5,21'h12345,1'b0,1'b0,1'b1,8'd5,21'h00000,1'b0,1'b0,1'b0,4'd10}, // R10
    '{1'b0,1'b0,1'b1,8'h02,21'h00000,1'b0,1'b0,1'b1,8'd2,21'h00A0B,1'b0,1'b0,1'b0,4'd11}, // R11
    '{1'b0,1'b1,1'b1,8'h03,21'h00000,1'b0,1'b0,1'b1,8'd3,21'h1FFFF,1'b0,1'b0,1'b0,4'd10}  // R10 R11
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic pu, input logic po, input logic wr, input logic [7:0] wd,
                      input logic [20:0] ad, input logic co, input logic cu, input logic en);
    @(negedge clk);
    push_i = pu; pop_i = po; ptr_wr_i = wr; ptr_wdata_i = wd; push_addr_i = ad;
    ovf_clr_i = co; unf_clr_i = cu; fault_rst_en_i = en;
    @(posedge clk);
    #1;
    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0; ptr_wr_i = 1'b0; ovf_clr_i = 1'b0; unf_clr_i = 1'b0;
  endtask

  task automatic check_all(input string tag, input logic [7:0] p, input logic [20:0] t,
                           input logic o, input logic u, input logic r);
    check({tag, " ptr"}, 32'(ptr_o), 32'(p));
    check({tag, " tos"}, 32'(tos_o), 32'(t));
    check({tag, " ovf"}, 32'(ovf_flag_o), 32'(o));
    check({tag, " unf"}, 32'(unf_flag_o), 32'(u));
    check({tag, " req"}, 32'(rst_req_o), 32'(r));
  endtask

  // Drive one cycle and sample 1 ns after the capturing edge.
  task automatic apply(input logic pu, input logic po, input logic wr, input logic [7:0] wd,
                       input logic [20:0] ad, input logic co, input logic cu, input logic en);
    @(negedge clk);
    push_i = pu; pop_i = po; ptr_wr_i = wr; ptr_wdata_i = wd; push_addr_i = ad;
    ovf_clr_i = co; unf_clr_i = cu; fault_rst_en_i = en;
    @(posedge clk);
    #1;
  endtask

  task automatic idle_in();
    push_i = 1'b0; pop_i = 1'b0; ptr_wr_i = 1'b0; ovf_clr_i = 1'b0; unf_clr_i = 1'b0;
  endtask

  initial begin
    // R1: state held in reset
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 in-reset", 8'd0, 21'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check_all("R1 released", 8'd0, 21'h0, 1'b0, 1'b0, 1'b0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].push, VEC[i].pop, VEC[i].wr, VEC[i].wdata, VEC[i].addr,
            VEC[i].clr_o, VEC[i].clr_u, VEC[i].en);
      check_all($sformatf("R%0d vec%0d", VEC[i].rq, i), VEC[i].e_ptr, VEC[i].e_tos,
                VEC[i].e_ovf, VEC[i].e_unf, VEC[i].e_req);
    end

    // R10: upper write bits ignored, load to level 30
    apply(1'b0, 1'b0, 1'b1, 8'hFE, 21'h0, 1'b0, 1'b0, 1'b1);
    check_all("R10 load30", 8'd30, 21'h0, 1'b0, 1'b0, 1'b0);
    // R2: last free slot
    apply(1'b1, 1'b0, 1'b0, 8'h00, 21'h0ABCD, 1'b0, 1'b0, 1'b1);
    check_all("R2 fill31", 8'd31, 21'h0ABCD, 1'b0, 1'b0, 1'b0);
    // R3 R7: push when full with reset enabled
    apply(1'b1, 1'b0, 1'b0, 8'h00, 21'h11111, 1'b0, 1'b0, 1'b1);
    check_all("R3 R7 overflow", 8'd31, 21'h0ABCD, 1'b1, 1'b0, 1'b1);
    // R7 pulse drops, R6 flag held
    apply(1'b0, 1'b0, 1'b0, 8'h00, 21'h0, 1'b0, 1'b0, 1'b1);
    check_all("R7 R6 after ovf", 8'd31, 21'h0ABCD, 1'b1, 1'b0, 1'b0);
    // R6 clear overflow flag
    apply(1'b0, 1'b0, 1'b0, 8'h00, 21'h0, 1'b1, 1'b0, 1'b1);
    check_all("R6 ovf clear", 8'd31, 21'h0ABCD, 1'b0, 1'b0, 1'b0);
    // R9 R8: push and pop at full, reset disabled: overflow, no request
    apply(1'b1, 1'b1, 1'b0, 8'h00, 21'h05555, 1'b0, 1'b0, 1'b0);
    check_all("R9 R8 both at full", 8'd31, 21'h0ABCD, 1'b1, 1'b0, 1'b0);
    // R4: pop from full exposes a never-written slot
    apply(1'b0, 1'b1, 1'b0, 8'h00, 21'h0, 1'b0, 1'b0, 1'b0);
    check_all("R4 pop from 31", 8'd30, 21'h0, 1'b1, 1'b0, 1'b0);

    // R1: reset mid-run clears everything
    @(negedge clk);
    idle_in();
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check_all("R1 mid-run reset", 8'd0, 21'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(1'b0, 1'b0, 1'b0, 8'h00, 21'h0, 1'b0, 1'b0, 1'b0);
    check_all("R1 after reset", 8'd0, 21'h0, 1'b0, 1'b0, 1'b0);

    @(negedge clk);
    idle_in();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule